// File: doc/BRIEF.md
# Ancillary Packet Checksum Checker and Corrector

This block sits in the path of a 10-bit serial digital video word stream. It finds ancillary data packets by their three-word flag. For each packet it adds up the words that the checksum covers and compares that sum with the checksum word carried in the packet. A mismatch in any packet marks the current field as having an ancillary error. When correction is on, the block replaces the carried checksum word with the computed one, so equipment further down the chain does not report the same error again. The block also flags carried checksum codes that fall in the forbidden top range.

Words enter and leave on valid/ready handshakes. The block marks each outgoing word that belongs to a packet with a strobe that travels with that word. A word moves on when its handshake completes, that is, when valid and ready are both high at a clock edge. The upstream side may raise `in_valid` at any time. The block lowers `in_ready` only when its lookahead window is full and the output word is held by a low `out_ready`. While `out_valid` is high and `out_ready` is low, the output word and its strobe stay fixed. The window holds the three most recent words. A word leaves only after three later words have been accepted, so the end of a stream has to be followed by filler words to drain it.

The field boundary input is a one-cycle pulse. At each pulse the flags gathered during the field that just ended are copied to the two flag outputs, and the gathering starts again from zero.

Top module: `anc_csum_fixer`

## Requirements
- R1: A packet starts at a word 000h that is followed directly by 3FFh and 3FFh. A 000h followed by anything else starts no packet.
- R2: `out_anc` is high on every output word from the 000h flag word through the checksum word, inclusive of both, and low on every other output word.
- R3: The sixth packet word is the data count. Its low 8 bits give the number of user data words, and its bits 9:8 are ignored. The checksum word comes directly after the last user data word, or directly after the data count word when the count is zero.
- R4: The computed checksum is the 9-bit sum, modulo 512, of bits 8:0 of every word from the data ID (the fourth packet word) through the last user data word. Bit 9 of the checksum is the inverse of its bit 8. A packet mismatches when its carried 10-bit checksum word differs from the computed one.
- R5: `anc_err` shows, from the edge that samples a `field_pulse` until the next such edge, whether any packet mismatched during the field that the pulse closed. It is 0 after reset.
- R6: Correction is on when `fix_pin` or `fix_host` is high, and off only when both are low. With correction on, the outgoing checksum word is the computed value. With correction off, it is the carried value.
- R7: With correction on, a carried checksum in 3FCh..3FFh is illegal. `bad_code` then reports that field in the same way `anc_err` does. With correction off, such codes raise no `bad_code`.
- R8: Every word other than a checksum word leaves unchanged, and all words leave in their order of arrival, none lost or repeated.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_anc` hold. `in_ready` is low only while `out_valid` is high and `out_ready` is low.
- R10: After reset, `out_valid`, `anc_err` and `bad_code` are 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Block can take the input word |
| in_data | input | 10 | Input video word |
| out_valid | output | 1 | Output word offered |
| out_ready | input | 1 | Downstream takes the output word |
| out_data | output | 10 | Output video word, checksum possibly replaced |
| out_anc | output | 1 | Output word belongs to an ancillary packet |
| field_pulse | input | 1 | One-cycle field boundary marker |
| fix_pin | input | 1 | Correction enable, pin source |
| fix_host | input | 1 | Correction enable, host source |
| anc_err | output | 1 | Last closed field had a checksum mismatch |
| bad_code | output | 1 | Last closed field had an illegal carried checksum |

## Verification
The bench sweeps the user data count from 0 through 6, and also uses a count of 255 carried in a data count word whose bits 9:8 are set unusually. This shows whether the checksum position and the end of the strobe follow the low count bits alone. Each count is paired with three kinds of carried checksum (correct, off by one bit, and a forbidden top code) and with all four settings of the two enable sources. Together these separate detection from correction, and separate the illegal-code flag from a plain mismatch. A false flag start, two packets placed back to back in one field, and a field with no packets show that recognition needs the full three-word flag, that errors gather across a field, and that the flags clear at the next boundary. A repeating stall on `out_ready` during half of the fields tests the hold rules under back-pressure.

// File: rtl/anccs_pkg.sv
package anccs_pkg;
  localparam int WORD_W  = 10;
  localparam int FLAG_N  = 3;   // words in the ancillary start flag
  localparam int COUNT_W = 8;   // user data count bits taken from the count word

  typedef enum logic [2:0] {
    PS_IDLE,
    PS_FLAG,
    PS_DID,
    PS_SDID,
    PS_DC,
    PS_UDW,
    PS_CS
  } pstate_e;
endpackage

// File: rtl/anccs_window.sv
module anccs_window #(
  parameter int W     = anccs_pkg::WORD_W,
  parameter int DEPTH = anccs_pkg::FLAG_N
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  output logic         full,
  output logic [W-1:0] oldest,
  output logic         flag_hit
);
  localparam int FW = $clog2(DEPTH + 1);

  logic [W-1:0]     slot_q [DEPTH];
  logic [FW-1:0]    fill_q;
  logic [DEPTH-1:0] hit_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
      fill_q <= '0;
    end else if (push) begin
      for (int i = DEPTH - 1; i > 0; i--) slot_q[i] <= slot_q[i-1];
      slot_q[0] <= din;
      if (fill_q != FW'(DEPTH)) fill_q <= fill_q + 1'b1;
    end
  end

  // oldest slot must be all zeros, every newer slot all ones
  for (genvar g = 0; g < DEPTH; g++) begin : g_match
    if (g == DEPTH - 1) begin : g_zero
      assign hit_v[g] = (slot_q[g] == '0);
    end else begin : g_ones
      assign hit_v[g] = (slot_q[g] == '1);
    end
  end

  assign full     = (fill_q == FW'(DEPTH));
  assign oldest   = slot_q[DEPTH-1];
  assign flag_hit = full && (&hit_v);
endmodule

// File: rtl/anccs_parser.sv
module anccs_parser #(
  parameter int W      = anccs_pkg::WORD_W,
  parameter int FLAG_N = anccs_pkg::FLAG_N,
  parameter int CNT_W  = anccs_pkg::COUNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic [W-1:0] word,
  input  logic         flag_hit,
  input  logic         fix_en,
  output logic [W-1:0] word_out,
  output logic         in_pkt,
  output logic         mismatch,
  output logic         illegal
);
  import anccs_pkg::*;

  localparam int SUM_W = W - 1;
  localparam int AL_W  = $clog2(FLAG_N + 1);

  pstate_e          st_q, st_d;
  logic [SUM_W-1:0] sum_q, sum_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [AL_W-1:0]  left_q, left_d;
  logic [W-1:0]     calc;

  assign calc = {~sum_q[SUM_W-1], sum_q};

  always_comb begin
    st_d     = st_q;
    sum_d    = sum_q;
    cnt_d    = cnt_q;
    left_d   = left_q;
    word_out = word;
    in_pkt   = 1'b1;
    mismatch = 1'b0;
    illegal  = 1'b0;
    unique case (st_q)
      PS_IDLE: begin
        in_pkt = flag_hit;
        if (flag_hit) begin
          st_d   = PS_FLAG;
          left_d = AL_W'(FLAG_N - 1);
        end
      end
      PS_FLAG: begin
        left_d = left_q - 1'b1;
        if (left_q == AL_W'(1)) st_d = PS_DID;
      end
      PS_DID: begin
        sum_d = word[SUM_W-1:0];
        st_d  = PS_SDID;
      end
      PS_SDID: begin
        sum_d = sum_q + word[SUM_W-1:0];
        st_d  = PS_DC;
      end
      PS_DC: begin
        sum_d = sum_q + word[SUM_W-1:0];
        cnt_d = word[CNT_W-1:0];
        st_d  = (word[CNT_W-1:0] == '0) ? PS_CS : PS_UDW;
      end
      PS_UDW: begin
        sum_d = sum_q + word[SUM_W-1:0];
        cnt_d = cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) st_d = PS_CS;
      end
      PS_CS: begin
        mismatch = step && (word != calc);
        illegal  = step && fix_en && (&word[W-1:2]);
        word_out = fix_en ? calc : word;
        st_d     = PS_IDLE;
      end
      default: begin
        in_pkt = 1'b0;
        st_d   = PS_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= PS_IDLE;
      sum_q  <= '0;
      cnt_q  <= '0;
      left_q <= '0;
    end else if (step) begin
      st_q   <= st_d;
      sum_q  <= sum_d;
      cnt_q  <= cnt_d;
      left_q <= left_d;
    end
  end
endmodule

// File: rtl/anccs_field_flags.sv
module anccs_field_flags #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         field_pulse,
  input  logic [N-1:0] event_in,
  output logic [N-1:0] report
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    logic sticky_q, report_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sticky_q <= 1'b0;
        report_q <= 1'b0;
      end else if (field_pulse) begin
        report_q <= sticky_q | event_in[g];
        sticky_q <= 1'b0;
      end else begin
        sticky_q <= sticky_q | event_in[g];
      end
    end
    assign report[g] = report_q;
  end
endmodule

// File: rtl/anc_csum_fixer.sv
module anc_csum_fixer #(
  parameter int W      = anccs_pkg::WORD_W,
  parameter int FLAG_N = anccs_pkg::FLAG_N,
  parameter int CNT_W  = anccs_pkg::COUNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data,
  output logic         out_anc,
  input  logic         field_pulse,
  input  logic         fix_pin,
  input  logic         fix_host,
  output logic         anc_err,
  output logic         bad_code
);
  logic         full, flag_hit, pop, accept, fix_en;
  logic [W-1:0] oldest, fixed_word;
  logic         in_pkt, mismatch, illegal;
  logic [1:0]   flags;
  logic         ov_q, oa_q;
  logic [W-1:0] od_q;

  assign fix_en   = fix_pin | fix_host;
  assign in_ready = !full || !ov_q || out_ready;
  assign accept   = in_valid && in_ready;
  assign pop      = accept && full;

  anccs_window #(.W(W), .DEPTH(FLAG_N)) u_window (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (accept),
    .din      (in_data),
    .full     (full),
    .oldest   (oldest),
    .flag_hit (flag_hit)
  );

  anccs_parser #(.W(W), .FLAG_N(FLAG_N), .CNT_W(CNT_W)) u_parser (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (pop),
    .word     (oldest),
    .flag_hit (flag_hit),
    .fix_en   (fix_en),
    .word_out (fixed_word),
    .in_pkt   (in_pkt),
    .mismatch (mismatch),
    .illegal  (illegal)
  );

  anccs_field_flags #(.N(2)) u_flags (
    .clk         (clk),
    .rst_n       (rst_n),
    .field_pulse (field_pulse),
    .event_in    ({illegal, mismatch}),
    .report      (flags)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ov_q <= 1'b0;
      oa_q <= 1'b0;
      od_q <= '0;
    end else if (pop) begin
      ov_q <= 1'b1;
      oa_q <= in_pkt;
      od_q <= fixed_word;
    end else if (out_ready) begin
      ov_q <= 1'b0;
    end
  end

  assign out_valid = ov_q;
  assign out_data  = od_q;
  assign out_anc   = oa_q;
  assign anc_err   = flags[0];
  assign bad_code  = flags[1];
endmodule

// File: rtl/anccs_chk.sv
module anccs_chk #(
  parameter int W = anccs_pkg::WORD_W
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_ready,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_data,
  input logic         out_anc,
  input logic         field_pulse,
  input logic         anc_err,
  input logic         bad_code
);
  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_anc));

  // R9
  ready_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> out_valid && !out_ready);

  // R9
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |-> $past(out_ready));

  // R5
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !field_pulse |=> $stable(anc_err));

  // R7
  code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !field_pulse |=> $stable(bad_code));
endmodule

bind anc_csum_fixer anccs_chk #(.W(W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_ready    (in_ready),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_data    (out_data),
  .out_anc     (out_anc),
  .field_pulse (field_pulse),
  .anc_err     (anc_err),
  .bad_code    (bad_code)
);

// File: tb/test_anc_csum_fixer.sv
module test_anc_csum_fixer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [9:0] in_data = '0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [9:0] out_data;
  logic       out_anc;
  logic       field_pulse = 1'b0;
  logic       fix_pin = 1'b0;
  logic       fix_host = 1'b0;
  logic       anc_err;
  logic       bad_code;

  always #10 clk = ~clk;

  anc_csum_fixer i_anc_csum_fixer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_anc(out_anc), .field_pulse(field_pulse),
    .fix_pin(fix_pin), .fix_host(fix_host), .anc_err(anc_err), .bad_code(bad_code)
  );

  int checks = 0;
  int errors = 0;
  logic [9:0] exp_d [0:4095];
  logic       exp_a [0:4095];
  int wr = 0;
  int rd = 0;
  logic stall_mode = 1'b0;
  logic fld_mis, fld_ill;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // back-pressure pattern
  initial begin
    int cyc = 0;
    forever begin
      @(negedge clk);
      cyc++;
      out_ready = stall_mode ? (cyc % 3 != 0) : 1'b1;
    end
  end

  // output monitor
  initial begin
    logic       held = 1'b0;
    logic [9:0] hd;
    logic       ha;
    forever begin
      @(negedge clk);
      #3;
      if (held) begin
        chk("R9 held word", {out_valid, out_anc, out_data}, {1'b1, ha, hd});
      end
      held = out_valid && !out_ready;
      hd = out_data;
      ha = out_anc;
      if (out_valid && out_ready && rd < wr) begin
        chk("R8 R6 word", out_data, exp_d[rd]);
        chk("R2 R3 strobe", out_anc, exp_a[rd]);
        rd++;
      end
    end
  end

  task automatic put(input logic [9:0] w, input logic [9:0] ew, input logic ea);
    logic done;
    exp_d[wr] = ew;
    exp_a[wr] = ea;
    wr++;
    in_valid = 1'b1;
    in_data  = w;
    done = 1'b0;
    while (!done) begin
      #2;
      done = in_ready;
      @(negedge clk);
    end
  endtask

  task automatic filler(input int k);
    for (int i = 0; i < k; i++) put((i % 2) ? 10'h200 : 10'h040, (i % 2) ? 10'h200 : 10'h040, 1'b0);
  endtask

  // kind: 0 correct, 1 one bit off, 2 forbidden code
  task automatic send_pkt(input int n, input logic [1:0] dc_hi, input int kind);
    logic [9:0] dc, calc, emb, u;
    logic [8:0] s;
    logic fx;
    fx = fix_pin | fix_host;
    dc = {dc_hi, 8'(n)};
    s = 9'(10'h241) + 9'(10'h102) + dc[8:0];
    put(10'h000, 10'h000, 1'b1);
    put(10'h3FF, 10'h3FF, 1'b1);
    put(10'h3FF, 10'h3FF, 1'b1);
    put(10'h241, 10'h241, 1'b1);
    put(10'h102, 10'h102, 1'b1);
    put(dc, dc, 1'b1);
    for (int i = 0; i < n; i++) begin
      u = 10'((n * 37 + i * 13 + 5) & 10'h3FF);
      s = s + u[8:0];
      put(u, u, 1'b1);
    end
    calc = {~s[8], s};
    emb = (kind == 0) ? calc : (kind == 1) ? (calc ^ 10'h001) : (10'h3FC + 10'(n % 4));
    put(emb, fx ? calc : emb, 1'b1);
    fld_mis = fld_mis | (emb != calc);
    fld_ill = fld_ill | (fx && emb >= 10'h3FC);
  endtask

  task automatic close_field(input string what);
    filler(3);
    in_valid = 1'b0;
    while (rd < wr - 3) @(negedge clk);
    repeat (2) @(negedge clk);
    field_pulse = 1'b1;
    @(negedge clk);
    field_pulse = 1'b0;
    #3;
    chk({"R4 R5 anc_err ", what}, anc_err, fld_mis);
    chk({"R7 bad_code ", what}, bad_code, fld_ill);
    @(negedge clk);
    fld_mis = 1'b0;
    fld_ill = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    fld_mis = 1'b0;
    fld_ill = 1'b0;
    repeat (3) @(negedge clk);
    #3;
    // R10 reset state
    chk("R10 out_valid", out_valid, 0);
    chk("R10 in_ready", in_ready, 1);
    chk("R10 anc_err", anc_err, 0);
    chk("R10 bad_code", bad_code, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 false starts are not packets
    filler(2);
    put(10'h000, 10'h000, 1'b0);
    put(10'h3FF, 10'h3FF, 1'b0);
    put(10'h040, 10'h040, 1'b0);
    put(10'h3FF, 10'h3FF, 1'b0);
    put(10'h3FF, 10'h3FF, 1'b0);
    close_field("false start");

    // main sweep: count x checksum kind x enable sources
    for (int n = 0; n <= 6; n++)
      for (int kind = 0; kind < 3; kind++)
        for (int c = 0; c < 4; c++) begin
          fix_pin = c[0];
          fix_host = c[1];
          stall_mode = c[0] ^ (kind == 1);
          filler(2);
          send_pkt(n, 2'b10, kind);
          close_field("sweep");
        end

    // R3 count uses low 8 bits only
    fix_pin = 1'b1;
    fix_host = 1'b0;
    stall_mode = 1'b1;
    filler(2);
    send_pkt(255, 2'b01, 1);
    close_field("count 255");

    // back-to-back packets, error in the second, correction off
    fix_pin = 1'b0;
    filler(2);
    send_pkt(2, 2'b10, 0);
    send_pkt(1, 2'b10, 1);
    close_field("back to back");

    // R5 an empty field clears the flags
    filler(4);
    close_field("empty");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule